// File: doc/BRIEF.md
# Interrupt and Bus Request Arbiter

This block sits beside a processor core's sequencer. At each boundary the core reports, it picks the one event that is served next. An external master asking for the bus is served at machine-cycle boundaries. A non-maskable interrupt and a maskable interrupt are served at instruction boundaries. The arbiter asserts the bus acknowledge. For an interrupt it instead emits a one-cycle service request together with a service kind and a 16-bit target. The core uses these to redirect its fetch.

The block holds the state that governs interrupt acceptance. This is the interrupt-enable flag, the two-bit interrupt mode and the 8-bit vector-page register. The core updates them through write strobes. The non-maskable input is edge-triggered, so its falling edge is captured in a pending flag that survives until that interrupt is taken. The maskable input is a plain low level. Fetching a table entry in vector mode and executing a device opcode in opcode mode are left to the core. The arbiter only hands over the byte the device drove during the acknowledge.

The reset input is asserted asynchronously. Its release is synchronised internally over two clock edges.

Top module: `svc_arbiter`

## Requirements
- R1: With `busreq_n` low in a cycle where `mcyc_end` is high, `bus_ack` is high from the next cycle on. It stays high while `busreq_n` stays low and falls in the cycle after `busreq_n` is sampled high. `busreq_n` low without `mcyc_end` does not assert `bus_ack`.
- R2: The bus request has priority over both interrupts. No service request is issued for an `instr_end` that arrives while `bus_ack` is high, or in the same cycle the bus is granted.
- R3: A falling edge on `nmi_n` sets a pending flag that takes effect one cycle later. The next `instr_end` then yields `svc_req` in the following cycle, with `svc_kind` = 1 and `svc_addr` = 16'h0066, whatever the enable flag holds.
- R4: When the non-maskable interrupt is pending and `irq_n` is low with the enable flag set, the non-maskable interrupt is served (kind 1) and the maskable one is not.
- R5: The maskable interrupt is a low level on `irq_n`, taken only at `instr_end` while `ie_q` is 1. With `ie_q` at 0 it produces no service request.
- R6: In mode 1 a taken maskable interrupt gives `svc_kind` = 3 and `svc_addr` = 16'h0038, independent of `ack_byte`.
- R7: In mode 2 a taken maskable interrupt gives `svc_kind` = 4 and `svc_addr` = {vector-page register, `ack_byte`}.
- R8: In mode 0 a taken maskable interrupt gives `svc_kind` = 2 and `svc_addr` = {8'h00, `ack_byte`}; the low byte is the opcode to execute.
- R9: Taking any interrupt clears `ie_q` in the same cycle `svc_req` rises, even if `ie_set` was high on the accepting edge. Otherwise `ie_set` sets the flag and `ie_clr` clears it.
- R10: The non-maskable pending flag clears only when that interrupt is served. A pulse shorter than an instruction is still served, and an input held low after service does not retrigger.
- R11: `mode_we` with `mode_val` = 3 is ignored and the previous mode is kept. `ireg_we` loads `ireg_val` into the vector-page register.
- R12: After reset, `bus_ack`, `svc_req`, `ie_q` are 0, `svc_kind` is 0 (none), `svc_addr` is 0, the mode is 0, the vector-page register is 0 and no non-maskable interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busreq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge triggered |
| irq_n | input | 1 | Maskable interrupt, active-low level |
| mcyc_end | input | 1 | Pulse: last cycle of a machine cycle |
| instr_end | input | 1 | Pulse: last cycle of an instruction |
| ie_set | input | 1 | Set the interrupt-enable flag |
| ie_clr | input | 1 | Clear the interrupt-enable flag |
| mode_we | input | 1 | Write strobe for the interrupt mode |
| mode_val | input | 2 | New interrupt mode (0, 1, 2) |
| ireg_we | input | 1 | Write strobe for the vector-page register |
| ireg_val | input | DATA_W | New vector-page value |
| ack_byte | input | DATA_W | Byte driven by the device during acknowledge |
| bus_ack | output | 1 | Bus handed to the external master |
| svc_req | output | 1 | One-cycle service request |
| svc_kind | output | 3 | 0 none, 1 non-maskable, 2 mode 0, 3 mode 1, 4 mode 2 |
| svc_addr | output | 2*DATA_W | Jump target or opcode of the last service |
| ie_q | output | 1 | Interrupt-enable flag |

## Verification
Every result is registered once. `bus_ack` is due one cycle after the `mcyc_end` cycle that saw the request, and `svc_req`, `svc_kind`, `svc_addr` and the cleared `ie_q` one cycle after the accepting `instr_end`. A non-maskable edge needs one cycle to reach the pending flag before an `instr_end` can use it. The bench drives inputs just after a falling clock edge. It advances its behavioural model at the rising edge and compares all outputs at the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks sample in that same slot. Stimulus starts only after the two-edge reset synchroniser has released.

// File: rtl/svc_arb_pkg.sv
package svc_arb_pkg;
  typedef enum logic [2:0] {
    SVC_NONE = 3'd0,
    SVC_NMI  = 3'd1,
    SVC_IM0  = 3'd2,
    SVC_IM1  = 3'd3,
    SVC_IM2  = 3'd4
  } svc_kind_e;

  localparam logic [15:0] NMI_TARGET = 16'h0066;
  localparam logic [15:0] IM1_TARGET = 16'h0038;
  localparam logic [1:0]  MODE_BAD   = 2'd3;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take,
  output logic pend
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic fall;

  always_comb begin
    fall   = prev_q & ~nmi_n;
    prev_d = nmi_n;
    pend_d = pend_q;
    if (take)
      pend_d = 1'b0;
    if (fall)
      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  AST_NMI_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_n) |=> pend); // R3
  AST_NMI_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !take) |=> pend); // R10
endmodule

// File: rtl/bus_grant.sv
module bus_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic busreq_n,
  input  logic mcyc_end,
  output logic bus_ack,
  output logic bus_busy
);
  logic ack_q, ack_d;
  logic grant;

  always_comb begin
    grant = mcyc_end & ~busreq_n & ~ack_q;
    ack_d = ack_q;
    if (grant)
      ack_d = 1'b1;
    else if (ack_q && busreq_n)
      ack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign bus_ack  = ack_q;
  assign bus_busy = ack_q | grant;

  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(mcyc_end && !busreq_n)); // R1
  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && !busreq_n) |=> bus_ack); // R1
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              accept,
  input  logic              mode_we,
  input  logic [1:0]        mode_val,
  input  logic              ireg_we,
  input  logic [DATA_W-1:0] ireg_val,
  output logic              ie_q,
  output logic [1:0]        mode_q,
  output logic [DATA_W-1:0] ireg_q
);
  import svc_arb_pkg::*;

  logic              ie_r, ie_d;
  logic [1:0]        mode_r, mode_d;
  logic [DATA_W-1:0] ireg_r, ireg_d;
  logic              mode_en, ireg_en;

  always_comb begin
    ie_d = ie_r;
    if (accept)      ie_d = 1'b0;
    else if (ie_set) ie_d = 1'b1;
    else if (ie_clr) ie_d = 1'b0;
    mode_en = mode_we & (mode_val != MODE_BAD);
    mode_d  = mode_val;
    ireg_en = ireg_we;
    ireg_d  = ireg_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_r   <= 1'b0;
      mode_r <= 2'd0;
      ireg_r <= '0;
    end else begin
      ie_r <= ie_d;
      if (mode_en) mode_r <= mode_d;
      if (ireg_en) ireg_r <= ireg_d;
    end
  end

  assign ie_q   = ie_r;
  assign mode_q = mode_r;
  assign ireg_q = ireg_r;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != MODE_BAD); // R11
  AST_ACCEPT_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ie_q); // R9
endmodule

// File: rtl/vector_gen.sv
module vector_gen #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              use_nmi,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] ireg,
  input  logic [DATA_W-1:0] ack_byte,
  output logic              req,
  output logic [2:0]        kind,
  output logic [ADDR_W-1:0] addr
);
  import svc_arb_pkg::*;

  logic              req_q, req_d;
  svc_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    req_d  = go;
    kind_d = kind_q;
    addr_d = addr_q;
    if (go) begin
      if (use_nmi) begin
        kind_d = SVC_NMI;
        addr_d = ADDR_W'(NMI_TARGET);
      end else begin
        case (mode)
          2'd0: begin
            kind_d = SVC_IM0;
            addr_d = {{DATA_W{1'b0}}, ack_byte};
          end
          2'd1: begin
            kind_d = SVC_IM1;
            addr_d = ADDR_W'(IM1_TARGET);
          end
          default: begin
            kind_d = SVC_IM2;
            addr_d = {ireg, ack_byte};
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      kind_q <= SVC_NONE;
      addr_q <= '0;
    end else begin
      req_q  <= req_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
    end
  end

  assign req  = req_q;
  assign kind = kind_q;
  assign addr = addr_q;

  AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (req && kind == SVC_NMI) |-> addr == ADDR_W'(NMI_TARGET)); // R3
  AST_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> $stable(kind)); // R8
endmodule

// File: rtl/svc_arbiter.sv
module svc_arbiter #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busreq_n,
  input  logic              nmi_n,
  input  logic              irq_n,
  input  logic              mcyc_end,
  input  logic              instr_end,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              mode_we,
  input  logic [1:0]        mode_val,
  input  logic              ireg_we,
  input  logic [DATA_W-1:0] ireg_val,
  input  logic [DATA_W-1:0] ack_byte,
  output logic              bus_ack,
  output logic              svc_req,
  output logic [2:0]        svc_kind,
  output logic [ADDR_W-1:0] svc_addr,
  output logic              ie_q
);
  import svc_arb_pkg::*;

  logic [1:0]        rst_sync;
  logic              srst_n;
  logic              bus_busy, nmi_pend, go, take_nmi;
  logic [1:0]        mode_q;
  logic [DATA_W-1:0] ireg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  always_comb begin
    go       = instr_end & ~bus_busy & (nmi_pend | (~irq_n & ie_q));
    take_nmi = go & nmi_pend;
  end

  bus_grant u_grant (
    .clk(clk), .rst_n(srst_n), .busreq_n(busreq_n), .mcyc_end(mcyc_end),
    .bus_ack(bus_ack), .bus_busy(bus_busy)
  );

  nmi_edge_latch u_nmi (
    .clk(clk), .rst_n(srst_n), .nmi_n(nmi_n), .take(take_nmi), .pend(nmi_pend)
  );

  ctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .ie_set(ie_set), .ie_clr(ie_clr), .accept(go),
    .mode_we(mode_we), .mode_val(mode_val), .ireg_we(ireg_we),
    .ireg_val(ireg_val), .ie_q(ie_q), .mode_q(mode_q), .ireg_q(ireg_q)
  );

  vector_gen #(.DATA_W(DATA_W)) u_vec (
    .clk(clk), .rst_n(srst_n), .go(go), .use_nmi(nmi_pend), .mode(mode_q),
    .ireg(ireg_q), .ack_byte(ack_byte), .req(svc_req), .kind(svc_kind),
    .addr(svc_addr)
  );

  AST_NO_SVC_UNDER_BUS: assert property (@(posedge clk) disable iff (!srst_n)
    svc_req |-> (!bus_ack && !$past(bus_ack))); // R2
  AST_INT_NEEDS_IE: assert property (@(posedge clk) disable iff (!srst_n)
    (svc_req && svc_kind != 3'(SVC_NMI)) |-> $past(ie_q)); // R5
  AST_IE_DROPS_ON_SVC: assert property (@(posedge clk) disable iff (!srst_n)
    svc_req |-> !ie_q); // R9
  AST_SVC_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(svc_req) |-> $past(instr_end)); // R5
endmodule

// File: tb/svc_arbiter_tb_top.sv
module svc_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, busreq_n, nmi_n, irq_n, mcyc_end, instr_end;
  logic ie_set, ie_clr, mode_we, ireg_we;
  logic [1:0] mode_val;
  logic [7:0] ireg_val, ack_byte;
  logic bus_ack, svc_req, ie_q;
  logic [2:0] svc_kind;
  logic [15:0] svc_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svc_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .busreq_n(busreq_n), .nmi_n(nmi_n), .irq_n(irq_n),
    .mcyc_end(mcyc_end), .instr_end(instr_end), .ie_set(ie_set), .ie_clr(ie_clr),
    .mode_we(mode_we), .mode_val(mode_val), .ireg_we(ireg_we), .ireg_val(ireg_val),
    .ack_byte(ack_byte), .bus_ack(bus_ack), .svc_req(svc_req), .svc_kind(svc_kind),
    .svc_addr(svc_addr), .ie_q(ie_q)
  );

  // behavioural reference, advanced on each rising edge
  bit m_prev, m_pend, m_ack, m_ie, m_req;
  int m_kind, m_mode;
  int m_addr, m_i;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 1; m_pend = 0; m_ack = 0; m_ie = 0; m_req = 0;
      m_kind = 0; m_addr = 0; m_mode = 0; m_i = 0;
    end else begin
      bit fall, grant, busy, go;
      fall  = m_prev && !nmi_n;
      m_prev = nmi_n;
      grant = mcyc_end && !busreq_n && !m_ack;
      busy  = m_ack || grant;
      go    = instr_end && !busy && (m_pend || (!irq_n && m_ie));
      m_req = go;
      if (go) begin
        if (m_pend) begin m_kind = 1; m_addr = 'h66; m_pend = 0; end
        else if (m_mode == 0) begin m_kind = 2; m_addr = ack_byte; end
        else if (m_mode == 1) begin m_kind = 3; m_addr = 'h38; end
        else begin m_kind = 4; m_addr = m_i * 256 + ack_byte; end
      end
      if (fall) m_pend = 1;
      if (grant) m_ack = 1;
      else if (m_ack && busreq_n) m_ack = 0;
      if (go) m_ie = 0;
      else if (ie_set) m_ie = 1;
      else if (ie_clr) m_ie = 0;
      if (mode_we && mode_val != 2'd3) m_mode = mode_val;
      if (ireg_we) m_i = ireg_val;
    end
  end

  function automatic string tag_of(int k);
    case (k)
      1: return "R3";
      2: return "R8";
      3: return "R6";
      4: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(bus_ack, m_ack, "R1", "bus_ack(model)");
    chk(svc_req, m_req, tag_of(m_req ? m_kind : 0), "svc_req(model)");
    chk(svc_kind, m_kind, tag_of(m_kind), "svc_kind(model)");
    chk(svc_addr, m_addr, tag_of(m_kind), "svc_addr(model)");
    chk(ie_q, m_ie, "R9", "ie_q(model)");
  endtask

  task automatic step();
    @(negedge clk);
    compare_model();
  endtask

  task automatic pulses_off();
    mcyc_end = 0; instr_end = 0; ie_set = 0; ie_clr = 0;
    mode_we = 0; ireg_we = 0;
  endtask

  task automatic set_mode(int m);
    mode_we = 1; mode_val = 2'(m); step(); mode_we = 0;
  endtask

  task automatic enable_ie();
    ie_set = 1; step(); ie_set = 0;
  endtask

  task automatic boundary();
    instr_end = 1; step(); instr_end = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; busreq_n = 1; nmi_n = 1; irq_n = 1; mode_val = 0;
    ireg_val = 0; ack_byte = 0;
    pulses_off();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) step();

    // R12 reset state, and the mode/register state seen through services
    chk(bus_ack, 0, "R12", "bus_ack");
    chk(svc_req, 0, "R12", "svc_req");
    chk(svc_kind, 0, "R12", "svc_kind");
    chk(svc_addr, 0, "R12", "svc_addr");
    chk(ie_q, 0, "R12", "ie_q");

    // R5: low irq with enable clear is ignored
    irq_n = 0; boundary();
    chk(svc_req, 0, "R5", "svc_req ie clear");
    // R12: mode 0 after reset, no pending nmi
    enable_ie(); ack_byte = 8'hC7; boundary();
    chk(svc_kind, 2, "R12", "mode after reset");
    chk(svc_addr, 16'h00C7, "R8", "mode0 addr");
    chk(ie_q, 0, "R9", "ie after accept");
    boundary();
    chk(svc_req, 0, "R9", "no re-entry");
    irq_n = 1;

    // R6 mode 1
    set_mode(1); enable_ie(); irq_n = 0; ack_byte = 8'h55; boundary();
    chk(svc_kind, 3, "R6", "kind");
    chk(svc_addr, 16'h0038, "R6", "addr");
    irq_n = 1;

    // R7 mode 2
    ireg_we = 1; ireg_val = 8'h12; set_mode(2); ireg_we = 0;
    enable_ie(); irq_n = 0; ack_byte = 8'h34; boundary();
    chk(svc_kind, 4, "R7", "kind");
    chk(svc_addr, 16'h1234, "R7", "addr");
    irq_n = 1;

    // R11: illegal mode write ignored
    set_mode(3); enable_ie(); irq_n = 0; ack_byte = 8'hA0; boundary();
    chk(svc_kind, 4, "R11", "kind after mode 3 write");
    chk(svc_addr, 16'h12A0, "R11", "addr after mode 3 write");
    irq_n = 1;

    // R8 mode 0 with 0xFF opcode
    set_mode(0); enable_ie(); irq_n = 0; ack_byte = 8'hFF; boundary();
    chk(svc_addr, 16'h00FF, "R8", "addr");
    irq_n = 1;

    // R10/R4: short nmi pulse, served later over a pending maskable irq
    enable_ie(); nmi_n = 0; step(); nmi_n = 1; repeat (3) step();
    irq_n = 0; boundary();
    chk(svc_kind, 1, "R4", "nmi beats irq");
    chk(svc_addr, 16'h0066, "R10", "short pulse kept");
    irq_n = 1;

    // R3: nmi with enable clear; held low does not retrigger (R10)
    nmi_n = 0; step(); step(); boundary();
    chk(svc_req, 1, "R3", "nmi ie clear");
    chk(svc_kind, 1, "R3", "kind");
    step(); boundary();
    chk(svc_req, 0, "R10", "held low no retrigger");
    nmi_n = 1; step();

    // R1/R2: grant at machine-cycle end beats coincident interrupt
    enable_ie(); irq_n = 0; busreq_n = 0; step();
    chk(bus_ack, 0, "R1", "no grant without mcyc_end");
    mcyc_end = 1; instr_end = 1; step(); mcyc_end = 0; instr_end = 0;
    chk(bus_ack, 1, "R1", "granted");
    chk(svc_req, 0, "R2", "no svc on grant edge");
    boundary();
    chk(svc_req, 0, "R2", "no svc under bus_ack");
    chk(bus_ack, 1, "R1", "held");
    busreq_n = 1; step();
    chk(bus_ack, 0, "R1", "released");
    boundary();
    chk(svc_req, 1, "R5", "served after release");
    irq_n = 1;

    // R9: set on accepting edge loses; explicit clear blocks irq
    enable_ie(); irq_n = 0; ie_set = 1; instr_end = 1; step(); pulses_off();
    chk(svc_req, 1, "R9", "accepted");
    chk(ie_q, 0, "R9", "clear wins over set");
    enable_ie(); ie_clr = 1; step(); ie_clr = 0; boundary();
    chk(svc_req, 0, "R9", "ie_clr blocks");
    irq_n = 1; repeat (3) step();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule